// File: doc/BRIEF.md
# Reloading Per-Core Tick Timer

This block is a per-core event timer. It sits behind a plain 32-bit register port with separate write and read strobes and drives a single interrupt line. The input clock first passes through a programmable prescaler. Each divided tick decrements an interrupt counter. When that counter expires, it reloads itself from a buffer register and raises a pending flag. The timer therefore keeps interrupting at a fixed period until software clears the run bits.

Every write to the prescaler buffer, the interrupt count buffer or the control register is acknowledged later through a sticky write-status bit. Software polls that bit and then clears it. The acknowledge delay models a clock-domain crossing. The written value itself takes effect at once. A write to the interrupt count buffer changes the count only when bit 31 of the data is set, which protects the count against stray writes.

Register offsets are word addresses: 0 control, 1 prescale buffer, 2 interrupt count buffer, 3 interrupt enable, 4 interrupt status, 5 write status.

Top module: `core_tick_timer`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: While control bit 0 (tick run) is set, one tick occurs every P+1 input clocks, where P is the prescale buffer at offset 1. While that bit is clear, no ticks occur.
- R3: A write to offset 2 loads data bits 30:0 into the interrupt count buffer only when data bit 31 is 1. Otherwise the buffer keeps its value. A read of offset 2 returns the 31-bit value with bit 31 as 0.
- R4: While control bit 1 (count run) and tick run are both set, the counter expires every max(N,1) ticks, with N being the buffer value. Each expiry sets the pending flag and reloads the counter, so expiries repeat. The first expiry after start comes N·(P+1) clock edges after the edge that writes the control register. With either run bit clear, the pending flag is never set.
- R5: The pending flag is bit 0 at offset 4. Writing 1 to that bit clears the flag. An expiry in the same cycle wins over the clear.
- R6: Write-status bits at offset 5 are bit 0 for a prescale-buffer write, bit 1 for a count-buffer write and bit 3 for a control write. Each bit becomes visible ACK_LAT (default 2) clock edges after the write edge. Each bit stays set until 1 is written to it.
- R7: `irq` equals the pending flag ANDed with bit 0 of the enable register at offset 3.
- R8: Reads of offsets 0 to 5 return the current register contents. A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| addr | input | AW | Word address of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The periodic function is exercised with pairs of prescale value and count value chosen to separate the two factors of the period. These include a zero prescale, a zero count, a count of one and larger values of each. A swapped or off-by-one factor therefore gives a distinct wrong cycle count. Each pair is measured twice, for the first expiry and for the expiry after a clear, which shows that the counter reloads rather than stopping or wrapping. Directed tests start only one run bit at a time to show that each gate alone blocks interrupts. They also hold the enable low while the flag is pending, write count data without bit 31, and time the write-status bits edge by edge.

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int ACK_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int CW = DW - 1;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PSC  = AW'(1);
  localparam logic [AW-1:0] A_CNT  = AW'(2);
  localparam logic [AW-1:0] A_IEN  = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_WACK = AW'(5);

  logic          run_tick, run_icnt, ien, pend;
  logic [DW-1:0] tick_buf, pcnt;
  logic [CW-1:0] icnt_buf, icnt;
  logic [2:0]    wst;
  logic [ACK_LAT-1:0][2:0] ack_q;

  wire w_ctrl = wr_en && addr == A_CTRL;
  wire w_psc  = wr_en && addr == A_PSC;
  wire w_cnt  = wr_en && addr == A_CNT;
  wire w_ien  = wr_en && addr == A_IEN;
  wire w_stat = wr_en && addr == A_STAT;
  wire w_wack = wr_en && addr == A_WACK;

  wire tick   = run_tick && (pcnt >= tick_buf);
  wire expire = tick && run_icnt && (icnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_tick <= 1'b0;
      run_icnt <= 1'b0;
      tick_buf <= '0;
      icnt_buf <= '0;
      ien      <= 1'b0;
    end else begin
      if (w_ctrl) {run_icnt, run_tick} <= wdata[1:0];
      if (w_psc) tick_buf <= wdata;
      if (w_cnt && wdata[DW-1]) icnt_buf <= wdata[CW-1:0];
      if (w_ien) ien <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_tick || tick) pcnt <= '0;
    else                             pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         icnt <= '0;
    else if (!run_icnt) icnt <= icnt_buf;
    else if (tick)      icnt <= (icnt <= CW'(1)) ? icnt_buf : icnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (expire)             pend <= 1'b1;
    else if (w_stat && wdata[0]) pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= '0;
    else begin
      ack_q[0] <= {w_ctrl, w_cnt, w_psc};
      for (int i = 1; i < ACK_LAT; i++) ack_q[i] <= ack_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wst <= '0;
    else begin
      if (ack_q[ACK_LAT-1][0])     wst[0] <= 1'b1;
      else if (w_wack && wdata[0]) wst[0] <= 1'b0;
      if (ack_q[ACK_LAT-1][1])     wst[1] <= 1'b1;
      else if (w_wack && wdata[1]) wst[1] <= 1'b0;
      if (ack_q[ACK_LAT-1][2])     wst[2] <= 1'b1;
      else if (w_wack && wdata[3]) wst[2] <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rdata = DW'({run_icnt, run_tick});
        A_PSC:   rdata = tick_buf;
        A_CNT:   rdata = {1'b0, icnt_buf};
        A_IEN:   rdata = DW'(ien);
        A_STAT:  rdata = DW'(pend);
        A_WACK:  rdata = DW'({wst[2], 1'b0, wst[1], wst[0]});
        default: rdata = '0;
      endcase
    end
  end

  assign irq = pend & ien;
endmodule

// File: rtl/core_tick_timer_chk.sv
module core_tick_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          wd0,
  input logic          wd3,
  input logic          wd31,
  input logic          irq,
  input logic          pend,
  input logic          ien,
  input logic          run_tick,
  input logic          run_icnt,
  input logic          tick,
  input logic [DW-1:0] pcnt,
  input logic [DW-2:0] icnt_buf,
  input logic          wst_ctrl
);
  p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_tick |=> pcnt == '0);
  p_cnt_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2) && !wd31) |=> $stable(icnt_buf));
  p_gated_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(run_tick && run_icnt));
  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4) && wd0 && !(tick && run_icnt)) |=> !pend);
  p_wack_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wst_ctrl && !(wr_en && addr == AW'(5) && wd3)) |=> wst_ctrl);
  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
endmodule

bind core_tick_timer core_tick_timer_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wd0(wdata[0]), .wd3(wdata[3]), .wd31(wdata[DW-1]),
  .irq(irq), .pend(pend), .ien(ien), .run_tick(run_tick),
  .run_icnt(run_icnt), .tick(tick), .pcnt(pcnt),
  .icnt_buf(icnt_buf), .wst_ctrl(wst[2])
);

// File: tb/core_tick_timer_tb_top.sv
`timescale 1ns/1ps
module core_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  core_tick_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // {prescale, count, expected period in edges}
  localparam logic [95:0] VEC [6] = '{
    {32'd0, 32'd3, 32'd3},
    {32'd1, 32'd2, 32'd4},
    {32'd2, 32'd4, 32'd12},
    {32'd4, 32'd1, 32'd5},
    {32'd3, 32'd0, 32'd4},
    {32'd6, 32'd2, 32'd14}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic measure(int start, output int c);
    c = start;
    while (!irq && c < 2000) begin
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reset reg", d, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R6 write acknowledge timing
    wr(3'd1, 32'd5);
    rd(3'd5, d); check("R6 ack edge0", d, 32'h0);
    @(negedge clk);
    rd(3'd5, d); check("R6 ack edge1", d, 32'h0);
    @(negedge clk);
    rd(3'd5, d); check("R6 ack prescale bit0", d, 32'h1);
    wr(3'd2, 32'h8000_0007);
    wr(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    rd(3'd5, d); check("R6 ack count+ctrl bits", d, 32'hB);
    wr(3'd5, 32'h2);
    repeat (3) @(negedge clk);
    rd(3'd5, d); check("R6 w1c bit1 only", d, 32'h9);
    wr(3'd5, 32'hB);
    repeat (3) @(negedge clk);
    rd(3'd5, d); check("R6 w1c all", d, 32'h0);

    // R3 guarded count buffer
    rd(3'd2, d); check("R3 load with bit31", d, 32'd7);
    wr(3'd2, 32'h0000_0055);
    rd(3'd2, d); check("R3 ignored without bit31", d, 32'd7);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R3 max count", d, 32'h7FFF_FFFF);
    rd(3'd1, d); check("R8 prescale readback", d, 32'd5);

    // R4 R2 periodic vectors
    for (int v = 0; v < 6; v++) begin
      wr(3'd0, 32'd0);
      wr(3'd4, 32'd1);
      wr(3'd1, VEC[v][95:64]);
      wr(3'd2, 32'h8000_0000 | VEC[v][63:32]);
      wr(3'd3, 32'd1);
      wr(3'd0, 32'd3);
      measure(0, c);
      check("R4 R2 first period", 32'(c), VEC[v][31:0]);
      wr(3'd4, 32'd1);
      check("R5 clear drops irq", {31'd0, irq}, 32'd0);
      measure(1, c);
      check("R4 reload period", 32'(c), VEC[v][31:0]);
    end

    // R7 masking
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd1);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h8000_0002);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd3);
    repeat (5) @(negedge clk);
    check("R7 masked irq", {31'd0, irq}, 32'd0);
    rd(3'd4, d); check("R5 pending set", d, 32'd1);
    wr(3'd3, 32'd1);
    check("R7 irq on enable", {31'd0, irq}, 32'd1);
    rd(3'd0, d); check("R8 ctrl readback", d, 32'd3);

    // R4 stop, single run bits
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd1);
    repeat (20) @(negedge clk);
    rd(3'd4, d); check("R4 stopped", d, 32'd0);
    wr(3'd0, 32'd1);
    repeat (20) @(negedge clk);
    rd(3'd4, d); check("R4 tick run only", d, 32'd0);
    wr(3'd0, 32'd2);
    repeat (20) @(negedge clk);
    rd(3'd4, d); check("R2 count run only", d, 32'd0);
    rd(3'd6, d); check("R8 unmapped", d, 32'd0);
    check("R7 irq idle", {31'd0, irq}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule